// File: doc/BRIEF.md
# Indirect Pointer Addressing Unit

This block resolves data-memory operands that are reached through pointer registers. It holds three 12-bit pointers, so each can reach any byte of a 4096-byte data space. Each pointer can be written one byte at a time at two direct register addresses. Each pointer also owns five virtual access slots. Reading or writing a slot reaches the byte that the pointer addresses, and the slot's mode decides how that address is formed and whether the pointer steps afterwards.

The instruction decoder gives the unit a decoded operand address, read and write strobes, write data and the working-register value. In the same cycle the unit drives the effective memory address, the memory read and write enables and the read data. The memory array is outside the block: the external array returns its data on `mem_rdata` combinationally, and writes take `op_wdata` at the next rising edge. Two flags go back to the decoder. One marks a zero produced by an indirect read that lands on a virtual slot, so that the decoder can set its zero flag. The other marks a pointer step, which must leave the status flags untouched. The unit also exports the contents of all pointers.

Top module: `ind_ptr_unit`

## Requirements
- R1: After reset every pointer holds 000h, and the synchronised reset holds all pointer registers for two rising edges after `rst_n` rises.
- R2: Pointer n has its low byte at address FE0h+2n and its high byte at FE0h+2n+1. A direct write updates only that byte. The upper four bits of a high-byte write are ignored, and a high-byte read returns them as zero. A read returns the byte in the same cycle, and no memory enable is raised.
- R3: Pointer n owns slots FE8h+8n+m. In mode m=0 (plain) the effective address is the pointer, and in m=4 (indexed) it is the pointer plus the working register sign-extended, modulo 4096. In both modes the pointer is unchanged.
- R4: In m=1 (post-decrement) and m=2 (post-increment) the unit presents the old pointer as the address. At the next edge the pointer becomes the old value minus or plus one across all 12 bits, so the carry or borrow passes between the bytes and the value wraps modulo 4096.
- R5: In m=3 (pre-increment) the address presented in the same cycle is the pointer plus one modulo 4096, and the pointer takes that value at the next edge.
- R6: When the effective address of a slot access is itself any virtual slot (m=0..4 of any pointer), a read returns 00h and raises `zero_rd`, a write changes nothing, and neither memory enable is raised. Addresses FE8h+8n+5 to +7 are ordinary memory.
- R7: When an indirect write has a pointer byte as its effective address, that byte takes the written data. If it belongs to the pointer that steps in the same access, the written byte wins: the other byte keeps its old value and the step is lost.
- R8: `upd_nf` is high exactly for accesses in modes 1, 2 or 3. It tells the decoder that the pointer change must not touch the status flags, even when the pointer steps to 000h.
- R9: Any other operand address is a direct memory access, and `mem_addr` equals the operand address. A read raises `mem_rd`, a write raises `mem_wr`, and the read data is `mem_rdata`. A write strobe takes precedence over a simultaneous read strobe.
- R10: Post-increment writes of 00h through pointer 0, started at 100h and stopped once bit 9 of the pointer is set, clear 100h to 1FFh in ascending order in 256 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_addr | input | 12 | Decoded operand address |
| op_rd | input | 1 | Operand read strobe |
| op_wr | input | 1 | Operand write strobe |
| op_wdata | input | 8 | Write data (also taken by the external memory) |
| wreg | input | 8 | Working-register value, used as a signed offset |
| mem_addr | output | 12 | Effective data-memory address |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Data returned by the memory for `mem_addr` |
| rd_data | output | 8 | Operand read result |
| zero_rd | output | 1 | Read of 00h caused by a self-referencing access |
| upd_nf | output | 1 | Pointer step this access; leave status flags alone |
| ptr_flat | output | 36 | Pointer contents, pointer n at bits 12n+11:12n |

## Verification
The address, the enables, the read data and both flags are combinational, so they belong to the cycle in which the stimulus is applied. The bench drives its inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. Pointer changes take effect on that rising edge, so the bench compares the pointers 1 ns after it against a model it has updated in the same way. The bench waits out the two-edge reset synchroniser before its first access, so that no pointer write falls inside the window in which reset is still being held.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  // Slot offset inside one pointer's 8-address group selects the access mode.
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTDEC = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_INDEX   = 3'd4
  } amode_e;

  localparam int SLOT_STRIDE = 8;
  localparam int NUM_MODES   = 5;
endpackage

// File: rtl/ptr_slot_decode.sv
// Recognises an operand address as one of the virtual pointer slots.
module ptr_slot_decode #(
  parameter int AW = 12,
  parameter int NPTR = 3,
  parameter logic [AW-1:0] VIRT_BASE = 12'hFE8,
  localparam int PW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          is_slot,
  output logic [PW-1:0] slot_ptr,
  output logic [2:0]    slot_mode
);
  import ptr_pkg::*;
  localparam logic [AW-1:0] SPAN = AW'(NPTR * SLOT_STRIDE);

  logic [AW-1:0] off;

  always_comb begin
    off       = addr - VIRT_BASE;
    slot_mode = off[2:0];
    slot_ptr  = off[PW+2:3];
    is_slot   = (off < SPAN) && (off[2:0] < 3'(NUM_MODES));
  end
endmodule

// File: rtl/ptr_tgt_class.sv
// Classifies an effective address: virtual slot, pointer byte, or memory.
module ptr_tgt_class #(
  parameter int AW = 12,
  parameter int NPTR = 3,
  parameter logic [AW-1:0] VIRT_BASE = 12'hFE8,
  parameter logic [AW-1:0] PTR_BASE = 12'hFE0,
  localparam int PW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          is_virt,
  output logic          is_preg,
  output logic [PW-1:0] preg_idx,
  output logic          preg_hi
);
  import ptr_pkg::*;
  localparam logic [AW-1:0] VSPAN = AW'(NPTR * SLOT_STRIDE);
  localparam logic [AW-1:0] PSPAN = AW'(NPTR * 2);

  logic [AW-1:0] voff;
  logic [AW-1:0] poff;

  always_comb begin
    voff     = addr - VIRT_BASE;
    poff     = addr - PTR_BASE;
    is_virt  = (voff < VSPAN) && (voff[2:0] < 3'(NUM_MODES));
    is_preg  = (poff < PSPAN);
    preg_idx = poff[PW:1];
    preg_hi  = poff[0];
  end
endmodule

// File: rtl/ptr_ea_calc.sv
// Forms the effective address and the stepped pointer for one access mode.
module ptr_ea_calc #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic [AW-1:0] ptr,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] wreg,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] ptr_nxt,
  output logic          steps
);
  import ptr_pkg::*;

  logic [AW-1:0] inc;
  logic [AW-1:0] dec;
  logic [AW-1:0] sofs;

  always_comb begin
    inc     = ptr + AW'(1);
    dec     = ptr - AW'(1);
    sofs    = {{(AW-DW){wreg[DW-1]}}, wreg};
    ea      = ptr;
    ptr_nxt = ptr;
    steps   = 1'b0;
    case (amode_e'(mode))
      AM_POSTDEC: begin ptr_nxt = dec; steps = 1'b1; end
      AM_POSTINC: begin ptr_nxt = inc; steps = 1'b1; end
      AM_PREINC:  begin ea = inc; ptr_nxt = inc; steps = 1'b1; end
      AM_INDEX:   ea = ptr + sofs;
      default:    ea = ptr;
    endcase
  end
endmodule

// File: rtl/ptr_bank.sv
// Pointer registers: byte writes dominate automatic steps.
module ptr_bank #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int NPTR = 3,
  localparam int PW = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int HB = AW - DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bw_en,
  input  logic [PW-1:0]    bw_idx,
  input  logic             bw_hi,
  input  logic [DW-1:0]    bw_data,
  input  logic             up_en,
  input  logic [PW-1:0]    up_idx,
  input  logic [AW-1:0]    up_val,
  output logic [NPTR*AW-1:0] ptr_flat
);
  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    logic [AW-1:0] q;
    logic [AW-1:0] d;
    logic          en;

    always_comb begin
      d  = q;
      en = 1'b0;
      if (bw_en && (bw_idx == PW'(k))) begin
        en = 1'b1;
        d  = bw_hi ? {bw_data[HB-1:0], q[DW-1:0]} : {q[AW-1:DW], bw_data};
      end else if (up_en && (up_idx == PW'(k))) begin
        en = 1'b1;
        d  = up_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign ptr_flat[k*AW +: AW] = q;
  end
endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int NPTR = 3,
  parameter logic [AW-1:0] VIRT_BASE = 12'hFE8,
  parameter logic [AW-1:0] PTR_BASE = 12'hFE0,
  localparam int PW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      op_addr,
  input  logic               op_rd,
  input  logic               op_wr,
  input  logic [DW-1:0]      op_wdata,
  input  logic [DW-1:0]      wreg,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  input  logic [DW-1:0]      mem_rdata,
  output logic [DW-1:0]      rd_data,
  output logic               zero_rd,
  output logic               upd_nf,
  output logic [NPTR*AW-1:0] ptr_flat
);
  // Reset: asserted asynchronously, released after two edges.
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  logic          acc, rd_only;
  logic          op_slot;
  logic [PW-1:0] op_ptr;
  logic [2:0]    op_mode;
  logic [AW-1:0] ptr_a [NPTR];
  logic [AW-1:0] ptr_sel, ea_ind, ptr_nxt, tgt;
  logic          steps;
  logic          t_virt, t_preg, t_hi;
  logic [PW-1:0] t_idx;
  logic [AW-1:0] t_ptr;

  assign acc     = op_rd | op_wr;
  assign rd_only = op_rd & ~op_wr;

  for (genvar k = 0; k < NPTR; k++) begin : g_unpack
    assign ptr_a[k] = ptr_flat[k*AW +: AW];
  end

  ptr_slot_decode #(.AW(AW), .NPTR(NPTR), .VIRT_BASE(VIRT_BASE)) i_slot (
    .addr(op_addr), .is_slot(op_slot), .slot_ptr(op_ptr), .slot_mode(op_mode)
  );

  assign ptr_sel = ptr_a[op_ptr];

  ptr_ea_calc #(.AW(AW), .DW(DW)) i_ea (
    .ptr(ptr_sel), .mode(op_mode), .wreg(wreg),
    .ea(ea_ind), .ptr_nxt(ptr_nxt), .steps(steps)
  );

  assign tgt = op_slot ? ea_ind : op_addr;

  ptr_tgt_class #(.AW(AW), .NPTR(NPTR), .VIRT_BASE(VIRT_BASE), .PTR_BASE(PTR_BASE)) i_tgt (
    .addr(tgt), .is_virt(t_virt), .is_preg(t_preg), .preg_idx(t_idx), .preg_hi(t_hi)
  );

  assign t_ptr = ptr_a[t_idx];

  always_comb begin
    mem_addr = tgt;
    mem_rd   = rd_only & ~t_virt & ~t_preg;
    mem_wr   = op_wr & ~t_virt & ~t_preg;
    zero_rd  = rd_only & t_virt;
    upd_nf   = acc & op_slot & steps;
    if (t_virt) begin
      rd_data = '0;
    end else if (t_preg) begin
      rd_data = t_hi ? DW'(t_ptr[AW-1:DW]) : t_ptr[DW-1:0];
    end else begin
      rd_data = mem_rdata;
    end
  end

  ptr_bank #(.AW(AW), .DW(DW), .NPTR(NPTR)) i_bank (
    .clk(clk), .rst_n(rst_sync_n),
    .bw_en(op_wr & t_preg), .bw_idx(t_idx), .bw_hi(t_hi), .bw_data(op_wdata),
    .up_en(acc & op_slot & steps), .up_idx(op_ptr), .up_val(ptr_nxt),
    .ptr_flat(ptr_flat)
  );
endmodule

// File: rtl/ind_ptr_unit_chk.sv
module ind_ptr_unit_chk #(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter int NPTR = 3,
  parameter logic [AW-1:0] VIRT_BASE = 12'hFE8,
  parameter logic [AW-1:0] PTR_BASE = 12'hFE0
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [AW-1:0]      op_addr,
  input logic               op_rd,
  input logic               op_wr,
  input logic [DW-1:0]      op_wdata,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic [DW-1:0]      rd_data,
  input logic               zero_rd,
  input logic               upd_nf,
  input logic [NPTR*AW-1:0] ptr_flat,
  input logic               t_virt,
  input logic [AW-1:0]      ea_ind
);
  logic [AW-1:0] p0;
  assign p0 = ptr_flat[AW-1:0];

  // R6: self-referencing target never reaches memory
  a_r6_virt_noop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((op_rd || op_wr) && t_virt) |-> (!mem_rd && !mem_wr));

  // R6: flagged zero read carries zero data
  a_r6_zero_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    zero_rd |-> (rd_data == '0));

  // R4: post-increment read through pointer 0 steps it by one
  a_r4_postinc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_rd && !op_wr && op_addr == VIRT_BASE + AW'(2)) |=> (p0 == $past(p0) + AW'(1)));

  // R4: post-decrement read through pointer 0 steps it down by one
  a_r4_postdec: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_rd && !op_wr && op_addr == VIRT_BASE + AW'(1)) |=> (p0 == $past(p0) - AW'(1)));

  // R3: indexed read leaves every pointer as it was
  a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_rd && !op_wr && op_addr == VIRT_BASE + AW'(4)) |=> $stable(ptr_flat));

  // R2: upper nibble of a high byte reads as zero
  a_r2_hi_nibble: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_rd && !op_wr && op_addr == PTR_BASE + AW'(1)) |-> (rd_data[DW-1:AW-DW] == '0));

  // R8: pre-increment access always reports a flag-free step
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((op_rd || op_wr) && op_addr == VIRT_BASE + AW'(3)) |-> upd_nf);

  // R7: indirect write onto pointer 0 low byte beats its own post-increment
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_wr && op_addr == VIRT_BASE + AW'(2) && ea_ind == PTR_BASE)
      |=> (p0 == {$past(p0[AW-1:DW]), $past(op_wdata)}));
endmodule

bind ind_ptr_unit ind_ptr_unit_chk #(
  .AW(AW), .DW(DW), .NPTR(NPTR), .VIRT_BASE(VIRT_BASE), .PTR_BASE(PTR_BASE)
) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .op_addr(op_addr), .op_rd(op_rd),
  .op_wr(op_wr), .op_wdata(op_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .rd_data(rd_data), .zero_rd(zero_rd), .upd_nf(upd_nf), .ptr_flat(ptr_flat),
  .t_virt(t_virt), .ea_ind(ea_ind)
);

// File: tb/test_ind_ptr_unit.sv
`timescale 1ns/100ps
module test_ind_ptr_unit;
  localparam logic [11:0] VB = 12'hFE8;
  localparam logic [11:0] PB = 12'hFE0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] op_addr;
  logic        op_rd, op_wr;
  logic [7:0]  op_wdata, wreg;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_rdata, rd_data;
  logic        zero_rd, upd_nf;
  logic [35:0] ptr_flat;

  logic [7:0]  bmem [4096];
  logic [11:0] mptr [3];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ind_ptr_unit i_ind_ptr_unit (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .op_rd(op_rd), .op_wr(op_wr),
    .op_wdata(op_wdata), .wreg(wreg), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_rdata(mem_rdata), .rd_data(rd_data), .zero_rd(zero_rd),
    .upd_nf(upd_nf), .ptr_flat(ptr_flat)
  );

  // External memory owned by the bench
  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) if (mem_wr) bmem[mem_addr] <= op_wdata;

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit slot_hit(input logic [11:0] a);
    logic [11:0] o;
    o = a - VB;
    return (o < 12'd24) && (o[2:0] < 3'd5);
  endfunction

  task automatic do_acc(input logic rd, input logic wr, input logic [11:0] a,
                        input logic [7:0] wd, input logic [7:0] w);
    logic ind, upd, tvirt, tpreg, thi;
    logic [1:0] n, tidx;
    logic [2:0] m;
    logic [11:0] p, ea, nx, tgt, po;
    logic [7:0] exp_rd;
    logic [11:0] np [3];
    string tg;
    @(negedge clk);
    op_rd = rd; op_wr = wr; op_addr = a; op_wdata = wd; wreg = w;
    ind = slot_hit(a);
    po = a - VB; n = po[4:3]; m = po[2:0];
    upd = 1'b0; ea = a; nx = '0;
    if (ind) begin
      p = mptr[n]; ea = p; nx = p;
      case (m)
        3'd1: begin nx = p - 12'd1; upd = 1'b1; end
        3'd2: begin nx = p + 12'd1; upd = 1'b1; end
        3'd3: begin ea = p + 12'd1; nx = ea; upd = 1'b1; end
        3'd4: ea = p + {{4{w[7]}}, w};
        default: ;
      endcase
    end
    tgt = ind ? ea : a;
    tvirt = slot_hit(tgt);
    po = tgt - PB;
    tpreg = (po < 12'd6); tidx = po[2:1]; thi = po[0];
    if (!ind) tg = tpreg ? "R2" : "R9";
    else if (tvirt) tg = "R6";
    else if (wr && tpreg) tg = "R7";
    else if (m == 3'd1 || m == 3'd2) tg = "R4";
    else if (m == 3'd3) tg = "R5";
    else tg = "R3";
    #1;
    if (!tvirt && !tpreg) chk({tg, " mem_addr"}, 36'(mem_addr), 36'(tgt));
    chk({tg, " mem_rd"}, 36'(mem_rd), 36'(rd && !wr && !tvirt && !tpreg));
    chk({tg, " mem_wr"}, 36'(mem_wr), 36'(wr && !tvirt && !tpreg));
    chk({tg, " zero_rd"}, 36'(zero_rd), 36'(rd && !wr && tvirt));
    chk("R8 upd_nf", 36'(upd_nf), 36'(upd));
    if (rd && !wr) begin
      if (tvirt) exp_rd = 8'h00;
      else if (tpreg) exp_rd = thi ? {4'h0, mptr[tidx][11:8]} : mptr[tidx][7:0];
      else exp_rd = bmem[tgt];
      chk({tg, " rd_data"}, 36'(rd_data), 36'(exp_rd));
    end
    for (int k = 0; k < 3; k++) np[k] = mptr[k];
    if (upd) np[n] = nx;
    if (wr && tpreg && !tvirt)
      np[tidx] = thi ? {wd[3:0], mptr[tidx][7:0]} : {mptr[tidx][11:8], wd};
    @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) mptr[k] = np[k];
    chk({tg, " pointers"}, ptr_flat, {mptr[2], mptr[1], mptr[0]});
    op_rd = 1'b0; op_wr = 1'b0;
  endtask

  task automatic set_ptr(input int n, input logic [11:0] v);
    do_acc(1'b0, 1'b1, PB + 12'(2*n+1), {4'h0, v[11:8]}, 8'h00);
    do_acc(1'b0, 1'b1, PB + 12'(2*n), v[7:0], 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [11:0] a;
    int r;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 4096; i++) bmem[i] = 8'(i * 7 + 3);
    for (int k = 0; k < 3; k++) mptr[k] = '0;
    rst_n = 1'b0; op_rd = 0; op_wr = 0; op_addr = '0; op_wdata = '0; wreg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R1 reset pointers", ptr_flat, 36'h0);

    // R2: byte writes, high nibble discarded, read back
    do_acc(1'b0, 1'b1, PB + 12'd5, 8'hAB, 8'h00);
    do_acc(1'b0, 1'b1, PB + 12'd4, 8'h34, 8'h00);
    do_acc(1'b1, 1'b0, PB + 12'd5, 8'h00, 8'h00);
    chk("R2 high byte value", 36'(mptr[2]), 36'hB34);
    do_acc(1'b1, 1'b0, PB + 12'd4, 8'h00, 8'h00);

    // R4: wrap and carry
    set_ptr(0, 12'h000);
    do_acc(1'b1, 1'b0, VB + 12'd1, 8'h00, 8'h00);
    chk("R4 borrow wrap", 36'(mptr[0]), 36'hFFF);
    do_acc(1'b1, 1'b0, VB + 12'd2, 8'h00, 8'h00);
    chk("R4 carry wrap", 36'(mptr[0]), 36'h000);
    set_ptr(0, 12'h0FF);
    do_acc(1'b1, 1'b0, VB + 12'd2, 8'h00, 8'h00);
    chk("R4 byte carry", 36'(mptr[0]), 36'h100);

    // R5: pre-increment wraps to 000
    set_ptr(0, 12'hFFF);
    do_acc(1'b1, 1'b0, VB + 12'd3, 8'h00, 8'h00);
    chk("R5 preinc wrap", 36'(mptr[0]), 36'h000);

    // R3: indexed with negative and positive offsets
    set_ptr(1, 12'h010);
    do_acc(1'b1, 1'b0, VB + 12'd12, 8'h00, 8'h80);
    do_acc(1'b1, 1'b0, VB + 12'd12, 8'h00, 8'h7F);
    do_acc(1'b0, 1'b1, VB + 12'd8, 8'h99, 8'h00);

    // R6: pointer aims at a virtual slot
    set_ptr(1, VB + 12'd2);
    do_acc(1'b1, 1'b0, VB + 12'd8, 8'h00, 8'h00);
    do_acc(1'b0, 1'b1, VB + 12'd8, 8'h5A, 8'h00);
    do_acc(1'b1, 1'b0, VB + 12'd10, 8'h00, 8'h00);
    // unused slot address is plain memory
    do_acc(1'b1, 1'b0, VB + 12'd5, 8'h00, 8'h00);

    // R7: write lands on the stepping pointer's own byte
    set_ptr(0, PB);
    do_acc(1'b0, 1'b1, VB + 12'd2, 8'h55, 8'h00);
    chk("R7 write beats step", 36'(mptr[0]), 36'hF55);
    set_ptr(0, PB + 12'd1);
    do_acc(1'b0, 1'b1, VB + 12'd1, 8'hC3, 8'h00);
    chk("R7 high write beats step", 36'(mptr[0]), 36'h3E1);
    set_ptr(1, PB);
    set_ptr(0, 12'h123);
    do_acc(1'b0, 1'b1, VB + 12'd9, 8'h77, 8'h00);

    // R10: clear loop over 100h..1FFh
    set_ptr(0, 12'h100);
    cnt = 0;
    while (!mptr[0][9] && cnt < 300) begin
      do_acc(1'b0, 1'b1, VB + 12'd2, 8'h00, 8'h00);
      cnt++;
    end
    chk("R10 loop count", 36'(cnt), 36'd256);
    r = 0;
    for (int i = 12'h100; i < 12'h200; i++) if (bmem[i] != 8'h00) r++;
    chk("R10 cleared bytes", 36'(r), 36'd0);
    chk("R10 next byte kept", 36'(bmem[12'h200]), 36'(8'(12'h200 * 7 + 3)));

    // Random mix
    for (int i = 0; i < 800; i++) begin
      r = int'($urandom % 100);
      if (r < 55) a = VB + 12'(($urandom % 3) * 8 + ($urandom % 5));
      else if (r < 70) a = PB + 12'($urandom % 6);
      else a = 12'($urandom);
      if ($urandom % 2 == 0) do_acc(1'b1, 1'b0, a, 8'h00, 8'($urandom));
      else do_acc(1'b0, 1'b1, a, 8'($urandom), 8'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule